// File: doc/BRIEF.md
# Operand Address Generation Unit

This unit sits beside the decode stage of an 8-bit accumulator CPU with a 16-bit address space. A decoder hands it a 3-bit addressing-mode code together with a start pulse while the program counter still holds the opcode's address. The unit then does three things:

- It requests the bytes that follow the opcode from a program-memory read port. That port returns one byte the cycle after each request.
- It advances its own program counter by one for the opcode and by one for each further byte it consumes.
- It produces the operand's effective address, or the immediate data byte, alongside a one-cycle done strobe and the instruction length.

The index register value is an input. The unit does not decode opcodes, perform ALU work, access data memory or execute branches. The branch offset of a bit-test branch is handed out untouched.

The controller has three states:

- `S_IDLE` waits for start. It goes to `S_BYTE1` when a legal mode needs further bytes, and otherwise stays in `S_IDLE`. The one-byte indexed form and illegal codes both finish in the start cycle.
- `S_BYTE1` receives the first byte after the opcode. It goes to `S_BYTE2` for three-byte modes and back to `S_IDLE` for two-byte modes.
- `S_BYTE2` receives the last byte and always returns to `S_IDLE`.

Top module: `opnd_addr_unit`

## Requirements
- R1: While reset is held and after it is released, done, illegal and fetch_req are 0, ea/operand/rel_off/ilen are 0, and pc equals the RESET_PC parameter (default 16'h0100).
- R2: Mode code 0 (immediate) is two bytes long. done rises one cycle after start, operand equals the fetched byte, ea is 0 and ilen is 2.
- R3: Mode code 1 (direct) is two bytes long. At done, ea = {8'h00, byte1} and ilen is 2.
- R4: Mode code 2 (extended) is three bytes long. done comes two cycles after start with ea = {byte1, byte2}, so byte1 is the high address byte, and ilen is 3.
- R5: Mode code 3 (indexed, no offset) fetches nothing. done is asserted in the start cycle itself with ea = {8'h00, x_reg} and ilen 1.
- R6: Mode code 4 (indexed, 8-bit offset) is two bytes long. ea is the unsigned 9-bit sum of x_reg and byte1 with bits 15:9 zero, so x=FF and offset FF give 16'h01FE.
- R7: Mode code 5 (bit-test branch) is three bytes long. At done, ea = {8'h00, byte1}, rel_off = byte2 unchanged, and ilen is 3.
- R8: Mode codes 6 and 7 raise illegal during the start cycle. They produce no fetch_req, no done and no change to pc.
- R9: Each fetch_req carries fetch_addr equal to the next sequential byte after the opcode, and the data is taken from pm_data one cycle later. After done, pc equals the opcode address plus ilen.
- R10: start is ignored while a fetch sequence is in progress. A new start is accepted in the cycle directly after done.
- R11: pc_load writes pc_load_addr into pc only while idle and when start is low. If start is high in the same cycle, the load is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin address formation for the opcode at pc |
| mode | input | 3 | Addressing-mode code |
| x_reg | input | 8 | Index register value |
| pc_load | input | 1 | Load a new program counter while idle |
| pc_load_addr | input | 16 | Value for pc_load |
| fetch_req | output | 1 | Program-memory read request |
| fetch_addr | output | 16 | Program-memory read address |
| pm_data | input | 8 | Byte returned one cycle after fetch_req |
| pc | output | 16 | Program counter |
| done | output | 1 | One-cycle completion strobe |
| ea | output | 16 | Effective address, valid with done |
| operand | output | 8 | Immediate data, valid with done |
| rel_off | output | 8 | Raw branch offset of bit-test branch, valid with done |
| ilen | output | 2 | Instruction length, valid with done |
| illegal | output | 1 | Unknown mode code seen on start |

## Verification
The embedded assertions watch properties that must hold on every cycle:

- a fetch request and done never coincide;
- an illegal code never fetches or completes;
- the program counter advances by exactly one on each consumed byte;
- a three-byte mode always passes through the second-byte state;
- every mode other than extended keeps address bits 15:9 clear.

The directed scenarios show what a single cycle cannot:

- the exact address values per mode, including the carry into bit 8 at FF+FF;
- the cycle in which done rises;
- the final program counter value;
- that a start during a busy sequence is dropped;
- that a pc_load colliding with start has no effect.

// File: rtl/opnd_addr_pkg.sv
package opnd_addr_pkg;

    typedef enum logic [2:0] {
        M_IMM  = 3'd0,
        M_DIR  = 3'd1,
        M_EXT  = 3'd2,
        M_IX0  = 3'd3,
        M_IX8  = 3'd4,
        M_BTB  = 3'd5,
        M_RSV6 = 3'd6,
        M_RSV7 = 3'd7
    } amode_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_BYTE1 = 2'd1,
        S_BYTE2 = 2'd2
    } seq_st_e;

    // Total instruction length in bytes, 0 for an unknown code.
    function automatic logic [1:0] mode_len(input amode_e m);
        logic [1:0] n;
        unique case (m)
            M_IX0:                      n = 2'd1;
            M_IMM, M_DIR, M_IX8:        n = 2'd2;
            M_EXT, M_BTB:               n = 2'd3;
            default:                    n = 2'd0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/agu_pc.sv
module agu_pc #(
    parameter int AW = 16,
    parameter logic [AW-1:0] RESET_PC = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    input  logic          load_en,
    input  logic [AW-1:0] load_addr,
    output logic [AW-1:0] pc_q,
    output logic [AW-1:0] next_byte_addr
);

    localparam logic [AW-1:0] ONE = AW'(1);

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= RESET_PC;
        else if (adv)
            pc_q <= pc_q + ONE;
        else if (load_en)
            pc_q <= load_addr;
    end

    assign next_byte_addr = pc_q + ONE;

    // R9
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        adv |=> pc_q == $past(pc_q) + ONE);

endmodule

// File: rtl/agu_seq.sv
module agu_seq
    import opnd_addr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic [2:0] mode_in,
    output amode_e  eff_mode,
    output seq_st_e state_q,
    output logic    fetch_req,
    output logic    pc_adv,
    output logic    cap_first,
    output logic    done,
    output logic    illegal,
    output logic    idle
);

    amode_e  mode_q;
    seq_st_e state_d;
    amode_e  req_mode;
    logic [1:0] req_len;

    assign req_mode = amode_e'(mode_in);
    assign req_len  = mode_len(req_mode);
    assign idle     = (state_q == S_IDLE);
    assign eff_mode = idle ? req_mode : mode_q;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            mode_q  <= M_IMM;
        end else begin
            state_q <= state_d;
            if (idle && start)
                mode_q <= req_mode;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d   = state_q;
        fetch_req = 1'b0;
        pc_adv    = 1'b0;
        cap_first = 1'b0;
        done      = 1'b0;
        illegal   = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    if (req_len == 2'd0) begin
                        illegal = 1'b1;
                    end else begin
                        pc_adv = 1'b1;
                        if (req_len == 2'd1) begin
                            done = 1'b1;
                        end else begin
                            fetch_req = 1'b1;
                            state_d   = S_BYTE1;
                        end
                    end
                end
            end
            S_BYTE1: begin
                pc_adv    = 1'b1;
                cap_first = 1'b1;
                if (mode_len(mode_q) == 2'd3) begin
                    fetch_req = 1'b1;
                    state_d   = S_BYTE2;
                end else begin
                    done    = 1'b1;
                    state_d = S_IDLE;
                end
            end
            S_BYTE2: begin
                pc_adv  = 1'b1;
                done    = 1'b1;
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // R9
    fetch_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(fetch_req && done));

    // R8
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!fetch_req && !done && !pc_adv));

    // R4
    three_byte_path_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_BYTE1 && mode_len(mode_q) == 2'd3) |=> state_q == S_BYTE2);

    // R10
    busy_no_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (!idle && !done) |=> $stable(mode_q));

endmodule

// File: rtl/agu_form.sv
module agu_form
    import opnd_addr_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  amode_e        eff_mode,
    input  logic          cap_first,
    input  logic          done,
    input  logic [DW-1:0] pm_data,
    input  logic [DW-1:0] x_reg,
    output logic [AW-1:0] ea,
    output logic [DW-1:0] operand,
    output logic [DW-1:0] rel_off,
    output logic [1:0]    ilen
);

    localparam int HW = AW - DW;
    localparam int SW = DW + 1;

    logic [DW-1:0] first_q;
    logic [SW-1:0] ix_sum;

    always_ff @(posedge clk) begin
        if (rst)
            first_q <= '0;
        else if (cap_first)
            first_q <= pm_data;
    end

    assign ix_sum = {1'b0, x_reg} + {1'b0, pm_data};

    always_comb begin
        ea      = '0;
        operand = '0;
        rel_off = '0;
        ilen    = 2'd0;
        if (done) begin
            ilen = mode_len(eff_mode);
            unique case (eff_mode)
                M_IMM: operand = pm_data;
                M_DIR: ea = {{HW{1'b0}}, pm_data};
                M_EXT: ea = {first_q[HW-1:0], pm_data};
                M_IX0: ea = {{HW{1'b0}}, x_reg};
                M_IX8: ea = {{(AW-SW){1'b0}}, ix_sum};
                M_BTB: begin
                    ea      = {{HW{1'b0}}, first_q};
                    rel_off = pm_data;
                end
                default: ea = '0;
            endcase
        end
    end

    // R6
    page_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (done && eff_mode != M_EXT) |-> ea[AW-1:SW] == '0);

    // R2
    imm_no_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (done && eff_mode == M_IMM) |-> ea == '0);

endmodule

// File: rtl/opnd_addr_unit.sv
module opnd_addr_unit
    import opnd_addr_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter logic [AW-1:0] RESET_PC = 16'h0100
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [2:0]    mode,
    input  logic [DW-1:0] x_reg,
    input  logic          pc_load,
    input  logic [AW-1:0] pc_load_addr,
    output logic          fetch_req,
    output logic [AW-1:0] fetch_addr,
    input  logic [DW-1:0] pm_data,
    output logic [AW-1:0] pc,
    output logic          done,
    output logic [AW-1:0] ea,
    output logic [DW-1:0] operand,
    output logic [DW-1:0] rel_off,
    output logic [1:0]    ilen,
    output logic          illegal
);

    amode_e  eff_mode;
    seq_st_e state_q;
    logic    pc_adv;
    logic    cap_first;
    logic    idle;
    logic    load_en;

    assign load_en = pc_load && idle && !start;

    agu_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .mode_in   (mode),
        .eff_mode  (eff_mode),
        .state_q   (state_q),
        .fetch_req (fetch_req),
        .pc_adv    (pc_adv),
        .cap_first (cap_first),
        .done      (done),
        .illegal   (illegal),
        .idle      (idle)
    );

    agu_pc #(.AW(AW), .RESET_PC(RESET_PC)) u_pc (
        .clk            (clk),
        .rst            (rst),
        .adv            (pc_adv),
        .load_en        (load_en),
        .load_addr      (pc_load_addr),
        .pc_q           (pc),
        .next_byte_addr (fetch_addr)
    );

    agu_form #(.AW(AW), .DW(DW)) u_form (
        .clk       (clk),
        .rst       (rst),
        .eff_mode  (eff_mode),
        .cap_first (cap_first),
        .done      (done),
        .pm_data   (pm_data),
        .x_reg     (x_reg),
        .ea        (ea),
        .operand   (operand),
        .rel_off   (rel_off),
        .ilen      (ilen)
    );

    // R11
    load_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        (pc_load && start && idle && mode_len(amode_e'(mode)) == 2'd0) |=> $stable(pc));

endmodule

// File: tb/opnd_addr_unit_bench.sv
`timescale 1ns/1ps
module opnd_addr_unit_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [2:0]  mode;
    logic [7:0]  x_reg;
    logic        pc_load;
    logic [15:0] pc_load_addr;
    logic [7:0]  pm_data;
    logic        fetch_req;
    logic [15:0] fetch_addr;
    logic [15:0] pc;
    logic        done;
    logic [15:0] ea;
    logic [7:0]  operand;
    logic [7:0]  rel_off;
    logic [1:0]  ilen;
    logic        illegal;

    logic [7:0]  mem [0:255];
    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    opnd_addr_unit u_opnd_addr_unit (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .x_reg(x_reg),
        .pc_load(pc_load), .pc_load_addr(pc_load_addr),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .pm_data(pm_data),
        .pc(pc), .done(done), .ea(ea), .operand(operand), .rel_off(rel_off),
        .ilen(ilen), .illegal(illegal)
    );

    always @(posedge clk) if (fetch_req) pm_data <= mem[fetch_addr[7:0]];

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_pc(input logic [15:0] a);
        @(negedge clk);
        pc_load = 1'b1; pc_load_addr = a;
        @(negedge clk);
        pc_load = 1'b0;
    endtask

    task automatic run(input logic [2:0] m, input logic [7:0] x, input logic [15:0] base,
                       output int dcyc, output logic [15:0] r_ea, output logic [7:0] r_op,
                       output logic [7:0] r_rel, output logic [1:0] r_len,
                       output int nfetch, output bit addr_ok);
        set_pc(base);
        x_reg = x; mode = m; start = 1'b1;
        dcyc = -1; nfetch = 0; addr_ok = 1'b1;
        r_ea = '0; r_op = '0; r_rel = '0; r_len = '0;
        for (int c = 0; c < 4; c++) begin
            #1;
            if (fetch_req) begin
                if (fetch_addr != base + 16'(1 + nfetch)) addr_ok = 1'b0;
                nfetch++;
            end
            if (done) begin
                dcyc = c; r_ea = ea; r_op = operand; r_rel = rel_off; r_len = ilen;
            end
            @(negedge clk);
            start = 1'b0;
            if (dcyc >= 0) break;
        end
    endtask

    task automatic t_reset;
        #1;
        chk(done == 0 && illegal == 0 && fetch_req == 0, "R1 flags", {done, illegal, fetch_req}, 0);
        chk(ea == 0 && ilen == 0, "R1 ea", ea, 0);
        chk(pc == 16'h0100, "R1 pc", pc, 16'h0100);
    endtask

    task automatic t_imm;
        int d, nf; logic [15:0] e; logic [7:0] o, r; logic [1:0] l; bit ok;
        mem[8'h11] = 8'hA5;
        run(3'd0, 8'h00, 16'h0010, d, e, o, r, l, nf, ok);
        chk(d == 1, "R2 done cycle", 16'(d), 1);
        chk(o == 8'hA5 && e == 0, "R2 operand", {o, e[7:0]}, 16'hA500);
        chk(l == 2, "R2 ilen", 16'(l), 2);
        chk(pc == 16'h0012 && nf == 1 && ok, "R9 pc imm", pc, 16'h0012);
    endtask

    task automatic t_dir;
        int d, nf; logic [15:0] e; logic [7:0] o, r; logic [1:0] l; bit ok;
        mem[8'h21] = 8'h7C;
        run(3'd1, 8'h00, 16'h0020, d, e, o, r, l, nf, ok);
        chk(d == 1 && e == 16'h007C, "R3 direct ea", e, 16'h007C);
        chk(l == 2 && pc == 16'h0022, "R3 len/pc", pc, 16'h0022);
    endtask

    task automatic t_ext;
        int d, nf; logic [15:0] e; logic [7:0] o, r; logic [1:0] l; bit ok;
        mem[8'h31] = 8'hC3; mem[8'h32] = 8'h5A;
        run(3'd2, 8'h00, 16'h0030, d, e, o, r, l, nf, ok);
        chk(d == 2, "R4 done cycle", 16'(d), 2);
        chk(e == 16'hC35A, "R4 ea", e, 16'hC35A);
        chk(l == 3, "R4 ilen", 16'(l), 3);
        chk(pc == 16'h0033 && nf == 2 && ok, "R9 ext fetch/pc", pc, 16'h0033);
    endtask

    task automatic t_ix0;
        int d, nf; logic [15:0] e; logic [7:0] o, r; logic [1:0] l; bit ok;
        run(3'd3, 8'h9E, 16'h0040, d, e, o, r, l, nf, ok);
        chk(d == 0 && nf == 0, "R5 done in start cycle", 16'(d), 0);
        chk(e == 16'h009E && l == 1, "R5 ea", e, 16'h009E);
        chk(pc == 16'h0041, "R5 pc", pc, 16'h0041);
    endtask

    task automatic ix8_case(input logic [7:0] x, input logic [7:0] off);
        int d, nf; logic [15:0] e; logic [7:0] o, r; logic [1:0] l; bit ok;
        logic [15:0] exp;
        exp = 16'(x) + 16'(off);
        mem[8'h51] = off;
        run(3'd4, x, 16'h0050, d, e, o, r, l, nf, ok);
        chk(d == 1 && e == exp && l == 2, "R6 indexed offset ea", e, exp);
    endtask

    task automatic t_ix8;
        ix8_case(8'hFF, 8'hFF);
        ix8_case(8'h10, 8'h20);
        ix8_case(8'h80, 8'h80);
        ix8_case(8'h00, 8'h00);
    endtask

    task automatic t_btb;
        int d, nf; logic [15:0] e; logic [7:0] o, r; logic [1:0] l; bit ok;
        mem[8'h61] = 8'h3B; mem[8'h62] = 8'hF0;
        run(3'd5, 8'h00, 16'h0060, d, e, o, r, l, nf, ok);
        chk(d == 2 && e == 16'h003B, "R7 branch ea", e, 16'h003B);
        chk(r == 8'hF0 && l == 3, "R7 rel_off", 16'(r), 16'h00F0);
        chk(pc == 16'h0063, "R7 pc", pc, 16'h0063);
    endtask

    task automatic t_illegal(input logic [2:0] m);
        set_pc(16'h0070);
        mode = m; start = 1'b1;
        #1;
        chk(illegal == 1 && fetch_req == 0 && done == 0, "R8 illegal start", {illegal, fetch_req, done}, 3'b100);
        @(negedge clk);
        start = 1'b0;
        #1;
        chk(done == 0 && pc == 16'h0070, "R8 pc unchanged", pc, 16'h0070);
    endtask

    task automatic t_busy;
        mem[8'h81] = 8'h12; mem[8'h82] = 8'h34;
        set_pc(16'h0080);
        mode = 3'd2; start = 1'b1;
        @(negedge clk);
        mode = 3'd3; x_reg = 8'h55; start = 1'b1;
        #1;
        chk(done == 0, "R10 start ignored while busy", 16'(done), 0);
        @(negedge clk);
        start = 1'b0;
        #1;
        chk(done == 1 && ea == 16'h1234, "R10 busy sequence result", ea, 16'h1234);
        @(negedge clk);
        start = 1'b1; mode = 3'd3;
        #1;
        chk(done == 1 && ea == 16'h0055, "R10 start after done", ea, 16'h0055);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic t_load;
        set_pc(16'h00A0);
        #1;
        chk(pc == 16'h00A0, "R11 load idle", pc, 16'h00A0);
        @(negedge clk);
        start = 1'b1; mode = 3'd3; pc_load = 1'b1; pc_load_addr = 16'h00F0;
        @(negedge clk);
        start = 1'b0; pc_load = 1'b0;
        #1;
        chk(pc == 16'h00A1, "R11 load ignored with start", pc, 16'h00A1);
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; mode = 3'd0; x_reg = 8'h00;
        pc_load = 1'b0; pc_load_addr = 16'h0000;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i);
        repeat (3) @(negedge clk);
        t_reset;
        @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_imm;
        t_dir;
        t_ext;
        t_ix0;
        t_ix8;
        t_btb;
        t_illegal(3'd6);
        t_illegal(3'd7);
        t_busy;
        t_load;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule